// File: doc/BRIEF.md
# Shared-Memory Bank Write Allocator

This block chooses, once per time slot, which of several parallel memory banks receives each fixed-size cell that arrives at the input ports of a shared-memory switch. Every arriving cell is placed in the same slot it arrives in; no input-side queue exists. The block keeps its own fill counter for each bank. It ranks the banks by that fill level, so the emptiest bank takes the next cell. A bank that is being read for a departure in the same slot, a bank that is full, and a bank already given to another cell in this slot are not candidates.

The surrounding switch drives a vector of arrival flags, one per input port, and a vector of read flags, one per bank, for the current slot. One clock later the block presents, for each port, either a grant with the chosen bank number or a drop flag. The updated fill counters are visible at the same time. Allocation is combinational from the registered counters, and results and counters are registered at the slot boundary. To keep drops rare, configure more banks than ports, so that a placement still exists while some banks are being read.

Top module: `bank_write_alloc`

## Requirements
- R1: While rst_n is low at a clock edge, all bank fill counters, grant_valid and drop become zero.
- R2: For each port p, grant_valid[p] and drop[p] are registered one clock after the slot. Exactly one of them is 1 if arr_valid[p] was 1 in that slot, and both are 0 otherwise.
- R3: A granted bank never has its rd_busy bit set in the slot of the grant.
- R4: Within one slot, no two ports receive the same bank.
- R5: A granted cell goes to the eligible bank with the lowest fill counter. Among equal counters the lowest bank number wins. The bank number for port p sits in grant_bank[p*IDX_W +: IDX_W].
- R6: Ports are served in ascending port order. Banks already granted to lower-numbered ports in the slot are not candidates for higher-numbered ports.
- R7: A bank whose counter equals DEPTH is not eligible. A port with an arrival and no eligible bank left gets drop instead of a grant.
- R8: A bank's counter, reported in occ_out[b*OCC_W +: OCC_W], rises by one after a granted write. It falls by one after a slot with its rd_busy bit set. A read of an empty bank leaves the counter at zero.
- R9: No counter ever exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_valid | input | NUM_PORTS | One cell arrives at port p this slot |
| rd_busy | input | NUM_BANKS | Bank b is read for a departure this slot |
| grant_valid | output | NUM_PORTS | Registered: cell of port p was placed |
| grant_bank | output | NUM_PORTS*IDX_W | Registered bank number per port |
| drop | output | NUM_PORTS | Registered: cell of port p found no bank |
| occ_out | output | NUM_BANKS*OCC_W | Current fill counter of each bank |

## Verification
The hardest situation to reach is a drop. It requires every bank that is not being read to be either full or already taken by a lower port in the same slot, while counters of different levels still compete in the ranking. The stimulus first runs a long stretch of full-rate arrivals with no reads until all banks fill and drops appear. It then drains with dense reads, including reads of empty banks. Finally it mixes full arrivals with reads that exclude most banks, so partial drops happen at middling fill levels. A behavioural model predicts grants, drops and counters for every slot and is compared each clock.

// File: rtl/bank_alloc_pkg.sv
// Package: shared helpers for the bank write allocator.
// Assumes: sizes are passed as positive integers.
package bank_alloc_pkg;
    // Bits needed to index n items, never less than one.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/bank_min_pick.sv
// Module: bank_min_pick
// Finds the eligible bank with the smallest fill counter. Ties go to the
// lowest bank number.
// Assumes: occ_flat packs bank b at [b*OCC_W +: OCC_W].
module bank_min_pick #(
    parameter int NUM_BANKS = 6,
    parameter int OCC_W     = 4,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_BANKS-1:0]       elig,
    input  logic [NUM_BANKS*OCC_W-1:0] occ_flat,
    output logic                       found,
    output logic [IDX_W-1:0]           idx
);
    logic [OCC_W-1:0] best_occ;

    // Linear scan; strict less-than keeps the lowest index on ties.
    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_occ = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (elig[b] && (!found || occ_flat[b*OCC_W +: OCC_W] < best_occ)) begin
                found    = 1'b1;
                idx      = IDX_W'(b);
                best_occ = occ_flat[b*OCC_W +: OCC_W];
            end
        end
    end
endmodule

// File: rtl/alloc_chain.sv
// Module: alloc_chain
// Serves ports in ascending order. Each stage picks from the banks left
// over by the stages before it.
// Assumes: base_elig already excludes banks that are being read or are full.
module alloc_chain #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_BANKS = 6,
    parameter int OCC_W     = 4,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_PORTS-1:0]       arr_valid,
    input  logic [NUM_BANKS-1:0]       base_elig,
    input  logic [NUM_BANKS*OCC_W-1:0] occ_flat,
    output logic [NUM_PORTS-1:0]       gnt,
    output logic [NUM_PORTS*IDX_W-1:0] gnt_bank,
    output logic [NUM_PORTS-1:0]       drp,
    output logic [NUM_BANKS-1:0]       wr_mask
);
    localparam logic [NUM_BANKS-1:0] ONE = {{(NUM_BANKS-1){1'b0}}, 1'b1};

    logic [NUM_BANKS-1:0] avail [NUM_PORTS+1];

    assign avail[0] = base_elig;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic             found;
        logic [IDX_W-1:0] idx;

        bank_min_pick #(
            .NUM_BANKS(NUM_BANKS), .OCC_W(OCC_W), .IDX_W(IDX_W)
        ) i_pick (
            .elig(avail[p]), .occ_flat(occ_flat), .found(found), .idx(idx)
        );

        // Grant, drop and removal of the chosen bank for later ports.
        always_comb begin
            gnt[p]                      = arr_valid[p] && found;
            drp[p]                      = arr_valid[p] && !found;
            gnt_bank[p*IDX_W +: IDX_W]  = found ? idx : '0;
            avail[p+1]                  = gnt[p] ? (avail[p] & ~(ONE << idx)) : avail[p];
        end
    end

    // Banks taken in this slot.
    assign wr_mask = base_elig & ~avail[NUM_PORTS];
endmodule

// File: rtl/occ_bank_counters.sv
// Module: occ_bank_counters
// One fill counter per bank. A write adds one; a read subtracts one unless
// the bank is already empty.
// Assumes: write and read never target the same bank in one slot.
module occ_bank_counters #(
    parameter int NUM_BANKS = 6,
    parameter int DEPTH     = 8,
    parameter int OCC_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS-1:0]       wr,
    input  logic [NUM_BANKS-1:0]       rd,
    output logic [NUM_BANKS*OCC_W-1:0] occ_flat,
    output logic [NUM_BANKS-1:0]       full
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [OCC_W-1:0] cnt;

        // Counter update at the slot boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)                  cnt <= '0;
            else if (wr[b])              cnt <= cnt + 1'b1;
            else if (rd[b] && cnt != '0) cnt <= cnt - 1'b1;
        end

        assign occ_flat[b*OCC_W +: OCC_W] = cnt;
        assign full[b] = (cnt == OCC_W'(DEPTH));
    end
endmodule

// File: rtl/bank_write_alloc.sv
// Module: bank_write_alloc (top)
// Places each arriving cell in the least-filled bank that is not being read,
// not full and not already taken this slot. Results are registered.
// Assumes: rd_busy marks the banks read in the same slot as arr_valid.
module bank_write_alloc
    import bank_alloc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_BANKS = 6,
    parameter int DEPTH     = 8,
    parameter int IDX_W     = idx_bits(NUM_BANKS),
    parameter int OCC_W     = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       arr_valid,
    input  logic [NUM_BANKS-1:0]       rd_busy,
    output logic [NUM_PORTS-1:0]       grant_valid,
    output logic [NUM_PORTS*IDX_W-1:0] grant_bank,
    output logic [NUM_PORTS-1:0]       drop,
    output logic [NUM_BANKS*OCC_W-1:0] occ_out
);
    logic [NUM_BANKS-1:0]       full;
    logic [NUM_BANKS-1:0]       wr_mask;
    logic [NUM_PORTS-1:0]       gnt_c;
    logic [NUM_PORTS-1:0]       drp_c;
    logic [NUM_PORTS*IDX_W-1:0] bank_c;

    occ_bank_counters #(
        .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .OCC_W(OCC_W)
    ) i_cnt (
        .clk(clk), .rst_n(rst_n), .wr(wr_mask), .rd(rd_busy),
        .occ_flat(occ_out), .full(full)
    );

    alloc_chain #(
        .NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS), .OCC_W(OCC_W), .IDX_W(IDX_W)
    ) i_chain (
        .arr_valid(arr_valid), .base_elig(~rd_busy & ~full), .occ_flat(occ_out),
        .gnt(gnt_c), .gnt_bank(bank_c), .drp(drp_c), .wr_mask(wr_mask)
    );

    // Register the placement result at the slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= '0;
            grant_bank  <= '0;
            drop        <= '0;
        end else begin
            grant_valid <= gnt_c;
            grant_bank  <= bank_c;
            drop        <= drp_c;
        end
    end
endmodule

// File: rtl/bank_write_alloc_chk.sv
// Module: bank_write_alloc_chk
// Property checker attached to bank_write_alloc. Observes its ports only.
module bank_write_alloc_chk #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_BANKS = 6,
    parameter int DEPTH     = 8,
    parameter int IDX_W     = 3,
    parameter int OCC_W     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_PORTS-1:0]       arr_valid,
    input logic [NUM_BANKS-1:0]       rd_busy,
    input logic [NUM_PORTS-1:0]       grant_valid,
    input logic [NUM_PORTS*IDX_W-1:0] grant_bank,
    input logic [NUM_PORTS-1:0]       drop,
    input logic [NUM_BANKS*OCC_W-1:0] occ_out
);
    logic [NUM_BANKS-1:0]       prev_rd;
    logic [NUM_BANKS*OCC_W-1:0] prev_occ;

    // Keep the previous slot's read flags and counters.
    always_ff @(posedge clk) begin
        prev_rd  <= rd_busy;
        prev_occ <= occ_out;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        // R2: one outcome per arrival, none without arrival.
        assert_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ((grant_valid[p] || drop[p]) == $past(arr_valid[p])) && !(grant_valid[p] && drop[p]));
        // R3: granted bank was not being read.
        assert_no_read_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid[p] |-> !prev_rd[grant_bank[p*IDX_W +: IDX_W]]);
        // R8: granted bank grew by one.
        assert_write_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid[p] |->
                occ_out[grant_bank[p*IDX_W +: IDX_W]*OCC_W +: OCC_W] ==
                prev_occ[grant_bank[p*IDX_W +: IDX_W]*OCC_W +: OCC_W] + 1'b1);
        for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_q
            // R4: distinct banks within a slot.
            assert_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_valid[p] && grant_valid[q]) |->
                    grant_bank[p*IDX_W +: IDX_W] != grant_bank[q*IDX_W +: IDX_W]);
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
        // R9: counter bounded by depth.
        assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            occ_out[b*OCC_W +: OCC_W] <= OCC_W'(DEPTH));
    end
endmodule

bind bank_write_alloc bank_write_alloc_chk #(
    .NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH),
    .IDX_W(IDX_W), .OCC_W(OCC_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .rd_busy(rd_busy),
    .grant_valid(grant_valid), .grant_bank(grant_bank), .drop(drop), .occ_out(occ_out)
);

// File: tb/test_bank_write_alloc.sv
module test_bank_write_alloc;
    localparam int P     = 4;
    localparam int B     = 6;
    localparam int DEPTH = 8;
    localparam int IW    = 3;
    localparam int OW    = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [P-1:0]    arr_valid = '0;
    logic [B-1:0]    rd_busy = '0;
    logic [P-1:0]    grant_valid;
    logic [P*IW-1:0] grant_bank;
    logic [P-1:0]    drop;
    logic [B*OW-1:0] occ_out;

    int checks = 0;
    int failures = 0;
    int drops_seen = 0;

    int occ_m [B];
    int exp_gv [P];
    int exp_gb [P];
    int exp_dr [P];
    logic [B-1:0] prev_busy = '0;

    always #5 clk = ~clk;

    bank_write_alloc #(.NUM_PORTS(P), .NUM_BANKS(B), .DEPTH(DEPTH)) i_bank_write_alloc (
        .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .rd_busy(rd_busy),
        .grant_valid(grant_valid), .grant_bank(grant_bank), .drop(drop), .occ_out(occ_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare the outputs with the model's prediction for the previous slot.
    task automatic compare_slot();
        for (int p = 0; p < P; p++) begin
            check(grant_valid[p] == exp_gv[p][0], "R2 grant", grant_valid[p], exp_gv[p]);
            check(drop[p] == exp_dr[p][0], "R7 drop", drop[p], exp_dr[p]);
            if (drop[p]) drops_seen++;
            if (exp_gv[p] != 0) begin
                check(int'(grant_bank[p*IW +: IW]) == exp_gb[p], "R5 R6 bank",
                      grant_bank[p*IW +: IW], exp_gb[p]);
                check(!prev_busy[grant_bank[p*IW +: IW]], "R3 read clash", 1, 0);
            end
        end
        for (int b = 0; b < B; b++) begin
            check(int'(occ_out[b*OW +: OW]) == occ_m[b], "R8 occupancy", occ_out[b*OW +: OW], occ_m[b]);
            check(int'(occ_out[b*OW +: OW]) <= DEPTH, "R9 bound", occ_out[b*OW +: OW], DEPTH);
        end
    endtask

    // Behavioural model: predict placement, then update counters.
    task automatic model_slot(input logic [P-1:0] av, input logic [B-1:0] busy);
        bit used [B];
        for (int b = 0; b < B; b++) used[b] = 0;
        for (int p = 0; p < P; p++) begin
            int best = -1;
            exp_gv[p] = 0; exp_dr[p] = 0; exp_gb[p] = 0;
            if (av[p]) begin
                for (int b = 0; b < B; b++)
                    if (!busy[b] && occ_m[b] < DEPTH && !used[b] && (best < 0 || occ_m[b] < occ_m[best]))
                        best = b;
                if (best < 0) exp_dr[p] = 1;
                else begin
                    exp_gv[p] = 1; exp_gb[p] = best; used[best] = 1;
                end
            end
        end
        for (int b = 0; b < B; b++) begin
            if (used[b]) occ_m[b]++;
            else if (busy[b] && occ_m[b] > 0) occ_m[b]--;
        end
        prev_busy = busy;
    endtask

    task automatic slot(input logic [P-1:0] av, input logic [B-1:0] busy);
        @(negedge clk);
        compare_slot();
        model_slot(av, busy);
        arr_valid = av;
        rd_busy   = busy;
    endtask

    function automatic logic [B-1:0] rand_mask(input int pct);
        logic [B-1:0] m = '0;
        for (int b = 0; b < B; b++) m[b] = (($urandom % 100) < pct);
        return m;
    endfunction

    function automatic logic [P-1:0] rand_arr(input int pct);
        logic [P-1:0] m = '0;
        for (int p = 0; p < P; p++) m[p] = (($urandom % 100) < pct);
        return m;
    endfunction

    initial begin
        #1ms;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int b = 0; b < B; b++) occ_m[b] = 0;
        for (int p = 0; p < P; p++) begin exp_gv[p] = 0; exp_gb[p] = 0; exp_dr[p] = 0; end
        // Dirty the state before reset to show R1 clears it.
        rst_n = 1'b1;
        repeat (3) begin @(negedge clk); arr_valid = '1; end
        @(negedge clk); rst_n = 1'b0; arr_valid = '0;
        repeat (3) @(negedge clk);
        check(occ_out == '0, "R1 counters", occ_out, 0);
        check(grant_valid == '0 && drop == '0, "R1 outputs", {grant_valid, drop}, 0);
        rst_n = 1'b1;

        // R6 directed: all empty, no reads -> ports take banks 0..3 in order.
        slot('1, '0);
        @(negedge clk);
        for (int p = 0; p < P; p++)
            check(int'(grant_bank[p*IW +: IW]) == p && grant_valid[p], "R6 order", grant_bank[p*IW +: IW], p);
        compare_slot();
        model_slot('0, '0);
        arr_valid = '0; rd_busy = '0;

        for (int i = 0; i < 100; i++) slot(rand_arr(50), rand_mask(30));
        for (int i = 0; i < 40; i++)  slot('1, '0);            // fill to full, R7 drops
        for (int i = 0; i < 60; i++)  slot('0, rand_mask(80)); // drain, empty reads
        for (int i = 0; i < 30; i++)  slot('1, '0);
        for (int i = 0; i < 60; i++)  slot('1, rand_mask(70)); // partial drops
        for (int i = 0; i < 200; i++) slot(rand_arr(60), rand_mask(40));
        slot('0, '0);
        slot('0, '0);
        check(drops_seen > 0, "R7 drops reached", drops_seen, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule